// File: doc/BRIEF.md
# Logical, Move and Add/Subtract Data Unit

This block is the operand-combining stage of a small RISC execution pipe. Each operation has a fixed three-operand form: a destination result, a first source and a second source. Only the second source may already have passed through the shifter ahead of this stage. The block is purely combinational. A 4-bit opcode selects one of nine functions, and the 32-bit result settles in the same cycle as the inputs.

The functions fall into three groups. The bitwise group has AND, OR, exclusive-OR and bit-clear. Bit-clear keeps the first-source bits wherever the second source holds a 0. The move group has a plain move and an inverting move, and both look only at the second source. The arithmetic group has add, subtract and reverse-subtract. Reverse-subtract exists because only the second source can be shifted: with it, a scaled operand can be the minuend, so b*8 - b gives b*7 without a multiplier. Arithmetic wraps modulo 2^32. No flags are produced.

Top module: `dpu_core`

## Requirements
- R1: Opcode 0 (AND) gives src1 & src2 in every bit.
- R2: Opcode 5 (OR) gives src1 | src2. A mask bit of 1 forces the result bit to 1, so 0x12345678 OR 0x0000FFFF gives 0x1234FFFF.
- R3: Opcode 1 (exclusive-OR) gives src1 ^ src2. A mask bit of 1 flips the src1 bit and a 0 keeps it.
- R4: Opcode 7 (bit-clear) gives src1 & ~src2. Every 1 in src2 clears that result bit, so 0x12345678 cleared with 0x0000FFFF gives 0x12340000.
- R5: Opcode 6 (move) gives src2 unchanged. The value of src1 has no effect on the result.
- R6: Opcode 8 (move inverted) gives ~src2, so a src2 of 0 gives 0xFFFFFFFF. The value of src1 has no effect on the result.
- R7: Opcode 4 (add) gives (src1 + src2) mod 2^32.
- R8: Opcode 2 (subtract) gives (src1 - src2) mod 2^32. The result wraps when src2 > src1.
- R9: Opcode 3 (reverse-subtract) gives (src2 - src1) mod 2^32. With src1 = x and src2 = x << 3, the result is 7*x mod 2^32.
- R10: Opcodes 9 to 15 are unused and give a result of 0 whatever the operands are.
- R11: The result depends only on the present inputs and follows any change to them within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src1_i | input | 32 | First source operand (never shifted) |
| src2_i | input | 32 | Second source operand, possibly pre-shifted |
| op_i | input | 4 | Operation select code |
| result_o | output | 32 | Combined result |

## Verification
The block holds no state, so an internal fault cannot linger. It shows up at once, in the same cycle, as a wrong result for the opcodes that use the faulty path. A swapped operand in the shared adder shows up only for subtract and reverse-subtract, and only when the operands differ. For that reason the bench uses unequal operands, including pairs that make the difference wrap. A bad decode shows up as a nonzero result on unused codes, or as a move that follows src1. The bench therefore changes src1 while src2 stays fixed, and sends operands with all bits set to the unused codes.

// File: rtl/dpu_pkg.sv
package dpu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0,
    OP_EOR = 4'd1,
    OP_SUB = 4'd2,
    OP_RSB = 4'd3,
    OP_ADD = 4'd4,
    OP_ORR = 4'd5,
    OP_MOV = 4'd6,
    OP_BIC = 4'd7,
    OP_MVN = 4'd8
  } dpu_op_e;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_ARITH = 2'd2
  } dpu_grp_e;

  function automatic dpu_grp_e op_group(input logic [OP_W-1:0] op);
    unique case (op)
      OP_AND, OP_EOR, OP_ORR, OP_MOV, OP_BIC, OP_MVN: op_group = GRP_LOGIC;
      OP_SUB, OP_RSB, OP_ADD:                         op_group = GRP_ARITH;
      default:                                        op_group = GRP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dpu_logic.sv
module dpu_logic
  import dpu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] y_o
);

  // One-hot function selects decoded once, shared by every bit slice.
  logic sel_and, sel_orr, sel_eor, sel_bic, sel_mov, sel_mvn;

  always_comb begin
    sel_and = (op_i == OP_AND);
    sel_orr = (op_i == OP_ORR);
    sel_eor = (op_i == OP_EOR);
    sel_bic = (op_i == OP_BIC);
    sel_mov = (op_i == OP_MOV);
    sel_mvn = (op_i == OP_MVN);
  end

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
    logic f_and, f_orr, f_eor, f_bic;
    always_comb begin
      f_and = a_i[gi] & b_i[gi];
      f_orr = a_i[gi] | b_i[gi];
      f_eor = a_i[gi] ^ b_i[gi];
      f_bic = a_i[gi] & ~b_i[gi];
      y_o[gi] = (sel_and &  f_and)   |
                (sel_orr &  f_orr)   |
                (sel_eor &  f_eor)   |
                (sel_bic &  f_bic)   |
                (sel_mov &  b_i[gi]) |
                (sel_mvn & ~b_i[gi]);
    end
  end

endmodule

// File: rtl/dpu_adder.sv
module dpu_adder
  import dpu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] y_o
);

  logic             swap;
  logic             negate;
  logic [WIDTH-1:0] lhs;
  logic [WIDTH-1:0] rhs;
  logic [WIDTH-1:0] cin_vec;

  // Reverse-subtract swaps the operands so one adder serves all three ops.
  always_comb begin
    swap    = (op_i == OP_RSB);
    negate  = (op_i == OP_SUB) || (op_i == OP_RSB);
    lhs     = swap ? b_i : a_i;
    rhs     = swap ? a_i : b_i;
    cin_vec = {{(WIDTH-1){1'b0}}, negate};
    y_o     = lhs + (negate ? ~rhs : rhs) + cin_vec;
  end

endmodule

// File: rtl/dpu_resmux.sv
module dpu_resmux
  import dpu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] logic_i,
  input  logic [WIDTH-1:0] arith_i,
  output logic [WIDTH-1:0] y_o
);

  dpu_grp_e grp;

  always_comb begin
    grp = op_group(op_i);
    unique case (grp)
      GRP_LOGIC: y_o = logic_i;
      GRP_ARITH: y_o = arith_i;
      default:   y_o = '0;
    endcase
  end

endmodule

// File: rtl/dpu_core.sv
module dpu_core
  import dpu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] src1_i,
  input  logic [WIDTH-1:0] src2_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o
);

  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] arith_res;

  dpu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (src1_i),
    .b_i  (src2_i),
    .op_i (op_i),
    .y_o  (logic_res)
  );

  dpu_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i  (src1_i),
    .b_i  (src2_i),
    .op_i (op_i),
    .y_o  (arith_res)
  );

  dpu_resmux #(.WIDTH(WIDTH)) u_mux (
    .op_i    (op_i),
    .logic_i (logic_res),
    .arith_i (arith_res),
    .y_o     (result_o)
  );

endmodule

// File: rtl/dpu_core_chk.sv
module dpu_core_chk
  import dpu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] src1_i,
  input logic [WIDTH-1:0] src2_i,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] result_o
);

  logic known;

  always_comb begin
    known = !$isunknown({src1_i, src2_i, op_i, result_o});
    if (known) begin
      if (op_i == OP_BIC) begin
        assert_bic_clears_R4: assert ((result_o & src2_i) == '0);
        assert_bic_keeps_R4:  assert ((result_o | src2_i) == (src1_i | src2_i));
      end
      if (op_i == OP_ORR) begin
        assert_orr_forces_R2: assert ((result_o & src2_i) == src2_i);
      end
      if (op_i == OP_EOR) begin
        assert_eor_undo_R3: assert ((result_o ^ src2_i) == src1_i);
      end
      if (op_i == OP_MOV) begin
        assert_mov_copy_R5: assert (result_o == src2_i);
      end
      if (op_i == OP_MVN) begin
        assert_mvn_compl_R6: assert ((result_o ^ src2_i) == '1);
      end
      if (op_i == OP_ADD) begin
        assert_add_inverse_R7: assert ((result_o - src2_i) == src1_i);
      end
      if (op_i == OP_SUB) begin
        assert_sub_inverse_R8: assert ((result_o + src2_i) == src1_i);
      end
      if (op_i == OP_RSB) begin
        assert_rsb_inverse_R9: assert ((result_o + src1_i) == src2_i);
      end
      if (op_i > OP_MVN) begin
        assert_unused_zero_R10: assert (result_o == '0);
      end
    end
  end

endmodule

bind dpu_core dpu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .src1_i   (src1_i),
  .src2_i   (src2_i),
  .op_i     (op_i),
  .result_o (result_o)
);

// File: tb/dpu_core_bench.sv
module dpu_core_bench;

  localparam int unsigned W = 32;
  localparam int unsigned WATCHDOG = 100000;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] src1, src2;
  logic [3:0]   op;
  logic [W-1:0] result;

  typedef struct {
    logic [W-1:0] exp;
    logic [3:0]   op;
    string        req;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  dpu_core u_dpu_core (
    .src1_i   (src1),
    .src2_i   (src2),
    .op_i     (op),
    .result_o (result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] model(input logic [3:0] o,
                                         input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    case (o)
      4'd0: model = a & b;
      4'd1: model = a ^ b;
      4'd2: model = a - b;
      4'd3: model = b - a;
      4'd4: model = a + b;
      4'd5: model = a | b;
      4'd6: model = b;
      4'd7: model = a & ~b;
      4'd8: model = ~b;
      default: model = '0;
    endcase
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0: tag = "R1";
      4'd5: tag = "R2";
      4'd1: tag = "R3";
      4'd7: tag = "R4";
      4'd6: tag = "R5";
      4'd8: tag = "R6";
      4'd4: tag = "R7";
      4'd2: tag = "R8";
      4'd3: tag = "R9";
      default: tag = "R10";
    endcase
  endfunction

  // Driver: applies one operation per cycle and pushes its expected result.
  task automatic drive(input logic [3:0] o, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] exp,
                       input string req);
    item_t it;
    @(posedge clk);
    #1;
    op = o; src1 = a; src2 = b;
    it.exp = exp; it.op = o; it.req = req;
    q.push_back(it);
  endtask

  task automatic drive_m(input logic [3:0] o, input logic [W-1:0] a,
                         input logic [W-1:0] b);
    drive(o, a, b, model(o, a, b), tag(o));
  endtask

  // Monitor: compares at the falling edge, well after inputs settled.
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (result !== it.exp) begin
        n_bad++;
        $display("FAIL %s op=%0d actual=%h expected=%h", it.req, it.op, result, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > WATCHDOG) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op = 4'd0; src1 = '0; src2 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: AND of zeros gives zero (R1)
    drive(4'd0, 32'h0, 32'h0, 32'h0, "R1 idle");
    drive(4'd0, 32'hB6A43D9A, 32'h00000FFF, 32'h00000D9A, "R1 mask");
    drive(4'd5, 32'h12345678, 32'h0000FFFF, 32'h1234FFFF, "R2 force");
    drive(4'd1, 32'h12345678, 32'h0000FFFF, 32'h1234A987, "R3 flip");
    drive(4'd7, 32'h12345678, 32'h0000FFFF, 32'h12340000, "R4 clear");
    drive(4'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, "R4 all");
    // R5: move ignores src1
    drive(4'd6, 32'h00000000, 32'hCAFEF00D, 32'hCAFEF00D, "R5 src1=0");
    drive(4'd6, 32'hFFFFFFFF, 32'hCAFEF00D, 32'hCAFEF00D, "R5 src1=ones");
    // R6: inverted move, zero in gives all ones, src1 ignored
    drive(4'd8, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, "R6 zero");
    drive(4'd8, 32'h5A5A5A5A, 32'h00000000, 32'hFFFFFFFF, "R6 src1 ignored");
    drive(4'd4, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, "R7 wrap");
    drive(4'd2, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, "R8 wrap");
    drive(4'd2, 32'h00000009, 32'h00000004, 32'h00000005, "R8 plain");
    drive(4'd3, 32'h00000009, 32'h00000004, 32'hFFFFFFFB, "R9 order");
    drive(4'd3, 32'd13, 32'd104, 32'd91, "R9 times7");
    // R10: unused codes with every bit set in both operands
    for (int c = 9; c < 16; c++)
      drive(4'(c), 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, "R10 unused");
    // R11: back-to-back changes, one new result every cycle
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      a = $urandom; b = $urandom;
      drive_m(4'($urandom_range(0, 15)), a, b);
    end
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] x;
      x = $urandom;
      drive(4'd3, x, x << 3, x * 7, "R9 R11 scaled");
    end
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule